// File: doc/BRIEF.md
# Parallel RGB Panel Sync Timing Generator

The block drives the timing side of a parallel RGB LCD link. From the system clock it derives a pixel rate, then runs a horizontal and a vertical counter that walk through four regions per axis: sync pulse, back porch, active area, front porch. From the counters it produces hsync, vsync, data enable, the position of the current active pixel, a pixel clock output and a frame interrupt that is raised as each frame's vsync begins.

Every region length arrives as a static input holding the length minus one. Each of hsync, vsync, data enable and the pixel clock has its own polarity inversion input. The pixel rate divider takes its ratio minus one together with a select bit. The video enable input is not applied at once: switching it off lets the current frame finish, and switching it on starts a frame at the next pixel tick. Region lengths are changed only while the generator is stopped. The inversion and divider inputs may change at any time.

Top module: `lcd_sync_gen`

## Requirements
- R1: During reset and after it, until video is enabled, hsync, vsync and data enable sit at their inactive levels (0 when not inverted), the pixel coordinates are 0 and the frame interrupt is 0.
- R2: A line lasts (hSyncLen+1)+(hBackLen+1)+(hActLen+1)+(hFrontLen+1) pixel ticks, in the order sync, back porch, active, front porch. hsync is asserted for the first hSyncLen+1 ticks of each line.
- R3: A frame lasts (vSyncLen+1)+(vBackLen+1)+(vActLen+1)+(vFrontLen+1) lines in the same region order. vsync is asserted for the first vSyncLen+1 lines. After the last tick of the last line, both counters return to the first tick of line 0.
- R4: Data enable is high only when both axes are in their active regions. pixX and pixY count from 0 at the first active pixel and the first active line, and read 0 whenever data enable is low.
- R5: invHsync, invVsync, invDe and invPclk each invert only their own output, and take effect from the next sample.
- R6: With divSel=1 and divRatioM1=N>0, one pixel tick occurs every N+1 system clocks. pclkOut (before inversion) is high while the divider phase is in 0..floor(N/2) and low for the rest of the period.
- R7: When divSel=0 or divRatioM1=0, the divider is bypassed: the counters advance every system clock and pclkOut (before inversion) follows the system clock.
- R8: Clearing videoEn stops output only after the last tick of the current frame; after that, all outputs stay inactive. Setting videoEn while stopped starts a frame at line 0, tick 0 on the next pixel tick.
- R9: When frameIrqEn=1, frameIrq is set in the same cycle that a frame starts (vsync begins). It holds until a cycle with frameIrqClr=1. If set and clear fall in the same cycle, the set wins.
- R10: When frameIrqEn=0, frame starts do not set frameIrq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hSyncLen | input | 11 | Horizontal sync width minus one, in pixel ticks |
| hBackLen | input | 11 | Horizontal back porch minus one |
| hActLen | input | 11 | Active width minus one |
| hFrontLen | input | 11 | Horizontal front porch minus one |
| vSyncLen | input | 11 | Vertical sync width minus one, in lines |
| vBackLen | input | 11 | Vertical back porch minus one |
| vActLen | input | 11 | Active height minus one |
| vFrontLen | input | 11 | Vertical front porch minus one |
| invHsync | input | 1 | Invert hsync |
| invVsync | input | 1 | Invert vsync |
| invDe | input | 1 | Invert data enable |
| invPclk | input | 1 | Invert pixel clock output |
| divSel | input | 1 | 1 selects the divided pixel clock |
| divRatioM1 | input | 8 | Divide ratio minus one |
| videoEn | input | 1 | Video enable, applied at frame boundary |
| frameIrqEn | input | 1 | Enables setting the frame interrupt |
| frameIrqClr | input | 1 | Clears the pending frame interrupt |
| pclkOut | output | 1 | Pixel clock to the panel |
| hsyncOut | output | 1 | Horizontal sync |
| vsyncOut | output | 1 | Vertical sync |
| deOut | output | 1 | Data enable |
| pixX | output | 11 | Active pixel column |
| pixY | output | 11 | Active line |
| frameIrq | output | 1 | Pending frame interrupt |

## Verification
The hardest situation to reach is a frame boundary that coincides with another event. Cases include video enable dropping partway through a frame, an interrupt clear held high across the frame start, and divider changes between frames. The stimulus lets a reference model of the counters run in step with the design. It then changes videoEn, the clear input and the divider settings at arbitrary cycles, and holds the clear high for several whole frames, so that every one of those coincidences lands on an edge that the scoreboard compares.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic run;      // a frame is in progress
    logic pixTick;  // counters advance this cycle
  } strobe_t;
endpackage

// File: rtl/lcd_sync_axis.sv
module lcd_sync_axis #(
  parameter int TW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          run,
  input  logic          step,
  input  logic [TW-1:0] syncLen,
  input  logic [TW-1:0] backLen,
  input  logic [TW-1:0] actLen,
  input  logic [TW-1:0] frontLen,
  output logic          atEnd,
  output logic          inSync,
  output logic          inActive,
  output logic [TW-1:0] pos
);
  localparam int CW = TW + 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] syncEnd, actStart, actEnd, lastCnt, offs;

  always_comb begin
    syncEnd  = CW'(syncLen) + CW'(1);
    actStart = syncEnd + CW'(backLen) + CW'(1);
    actEnd   = actStart + CW'(actLen) + CW'(1);
    lastCnt  = actEnd + CW'(frontLen);
    atEnd    = (cnt >= lastCnt);
    inSync   = run && (cnt < syncEnd);
    inActive = run && (cnt >= actStart) && (cnt < actEnd);
    offs     = cnt - actStart;
    pos      = inActive ? offs[TW-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (step)    cnt <= atEnd ? '0 : cnt + CW'(1);
  end

  // R2/R3: counter never passes the last position of its axis
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (cnt <= lastCnt));
  // R2: counter holds between steps
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (run && !step) |=> $stable(cnt));
endmodule

// File: rtl/lcd_sync_ctrl.sv
module lcd_sync_ctrl
  import lcd_sync_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          divSel,
  input  logic [DW-1:0] divRatioM1,
  input  logic          invPclk,
  input  logic          videoEn,
  input  logic          frameIrqEn,
  input  logic          frameIrqClr,
  input  logic          frameEnd,
  output strobe_t       strobe,
  output logic          pclkOut,
  output logic          frameIrq
);
  logic [DW-1:0] divCnt;
  logic bypass, pixTick, run, frameStart, irqPend, pclkPhase;

  always_comb begin
    bypass     = !divSel || (divRatioM1 == '0);
    pixTick    = bypass || (divCnt >= divRatioM1);
    frameStart = pixTick && videoEn && (!run || frameEnd);
    pclkPhase  = bypass ? clk : (divCnt <= (divRatioM1 >> 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         divCnt <= '0;
    else if (pixTick)  divCnt <= '0;
    else               divCnt <= divCnt + DW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          run <= 1'b0;
    else if (frameStart)                run <= 1'b1;
    else if (run && pixTick && frameEnd) run <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             irqPend <= 1'b0;
    else if (frameStart && frameIrqEn)     irqPend <= 1'b1;
    else if (frameIrqClr)                  irqPend <= 1'b0;
  end

  assign strobe.run     = run;
  assign strobe.pixTick = pixTick;
  assign pclkOut        = pclkPhase ^ invPclk;
  assign frameIrq       = irqPend;

  // R6: divided ticks never come on two consecutive cycles with a steady setting
  p_div_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!bypass && pixTick) |=> (!pixTick || !$stable(divRatioM1) || !$stable(divSel)));
  // R8: a running frame only stops on its last tick
  p_run_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (run && !(pixTick && frameEnd)) |=> run);
  // R9: a frame start with the interrupt enabled leaves it pending
  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && frameIrqEn) |=> irqPend);
  // R10: no pending bit appears without an enabled frame start
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!irqPend && !(frameStart && frameIrqEn)) |=> !irqPend);
endmodule

// File: rtl/lcd_sync_dp.sv
module lcd_sync_dp
  import lcd_sync_pkg::*;
#(
  parameter int TW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobe,
  input  logic [TW-1:0] hSyncLen,
  input  logic [TW-1:0] hBackLen,
  input  logic [TW-1:0] hActLen,
  input  logic [TW-1:0] hFrontLen,
  input  logic [TW-1:0] vSyncLen,
  input  logic [TW-1:0] vBackLen,
  input  logic [TW-1:0] vActLen,
  input  logic [TW-1:0] vFrontLen,
  input  logic          invHsync,
  input  logic          invVsync,
  input  logic          invDe,
  output logic          frameEnd,
  output logic          hsyncOut,
  output logic          vsyncOut,
  output logic          deOut,
  output logic [TW-1:0] pixX,
  output logic [TW-1:0] pixY
);
  logic hEnd, hSync, hAct, vEnd, vSync, vAct, deRaw;
  logic [TW-1:0] hPos, vPos;

  lcd_sync_axis #(.TW(TW)) uHoriz (
    .clk(clk), .rstN(rstN), .run(strobe.run), .step(strobe.pixTick),
    .syncLen(hSyncLen), .backLen(hBackLen), .actLen(hActLen), .frontLen(hFrontLen),
    .atEnd(hEnd), .inSync(hSync), .inActive(hAct), .pos(hPos));

  lcd_sync_axis #(.TW(TW)) uVert (
    .clk(clk), .rstN(rstN), .run(strobe.run), .step(strobe.pixTick && hEnd),
    .syncLen(vSyncLen), .backLen(vBackLen), .actLen(vActLen), .frontLen(vFrontLen),
    .atEnd(vEnd), .inSync(vSync), .inActive(vAct), .pos(vPos));

  always_comb begin
    frameEnd = strobe.run && hEnd && vEnd;
    deRaw    = hAct && vAct;
    hsyncOut = hSync ^ invHsync;
    vsyncOut = vSync ^ invVsync;
    deOut    = deRaw ^ invDe;
    pixX     = deRaw ? hPos : '0;
    pixY     = deRaw ? vPos : '0;
  end

  // R3: the last tick of a frame lands both axes on their first position
  p_frame_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pixTick && frameEnd) |=> (hSync && vSync) || !strobe.run);
  // R4: data enable never occurs while stopped
  p_de_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |-> !deRaw);
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int TW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [TW-1:0] hSyncLen,
  input  logic [TW-1:0] hBackLen,
  input  logic [TW-1:0] hActLen,
  input  logic [TW-1:0] hFrontLen,
  input  logic [TW-1:0] vSyncLen,
  input  logic [TW-1:0] vBackLen,
  input  logic [TW-1:0] vActLen,
  input  logic [TW-1:0] vFrontLen,
  input  logic          invHsync,
  input  logic          invVsync,
  input  logic          invDe,
  input  logic          invPclk,
  input  logic          divSel,
  input  logic [DW-1:0] divRatioM1,
  input  logic          videoEn,
  input  logic          frameIrqEn,
  input  logic          frameIrqClr,
  output logic          pclkOut,
  output logic          hsyncOut,
  output logic          vsyncOut,
  output logic          deOut,
  output logic [TW-1:0] pixX,
  output logic [TW-1:0] pixY,
  output logic          frameIrq
);
  strobe_t strobe;
  logic    frameEnd;

  lcd_sync_ctrl #(.DW(DW)) uCtrl (
    .clk(clk), .rstN(rstN), .divSel(divSel), .divRatioM1(divRatioM1),
    .invPclk(invPclk), .videoEn(videoEn), .frameIrqEn(frameIrqEn),
    .frameIrqClr(frameIrqClr), .frameEnd(frameEnd), .strobe(strobe),
    .pclkOut(pclkOut), .frameIrq(frameIrq));

  lcd_sync_dp #(.TW(TW)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hSyncLen(hSyncLen), .hBackLen(hBackLen), .hActLen(hActLen), .hFrontLen(hFrontLen),
    .vSyncLen(vSyncLen), .vBackLen(vBackLen), .vActLen(vActLen), .vFrontLen(vFrontLen),
    .invHsync(invHsync), .invVsync(invVsync), .invDe(invDe),
    .frameEnd(frameEnd), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .deOut(deOut), .pixX(pixX), .pixY(pixY));
endmodule

// File: tb/lcd_sync_gen_test.sv
`timescale 1ns/1ps
module lcd_sync_gen_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [10:0] hSyncLen, hBackLen, hActLen, hFrontLen;
  logic [10:0] vSyncLen, vBackLen, vActLen, vFrontLen;
  logic invHsync, invVsync, invDe, invPclk, divSel, videoEn, frameIrqEn, frameIrqClr;
  logic [7:0] divRatioM1;
  logic pclkOut, hsyncOut, vsyncOut, deOut, frameIrq;
  logic [10:0] pixX, pixY;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lcd_sync_gen uut (.*);

  typedef struct { bit run; int h; int v; int dv; bit irq; } snap_t;
  snap_t expQ[$];

  // reference model of the state visible at the ports
  bit mRun; int mH, mV, mDiv; bit mIrq;
  always @(posedge clk) begin
    snap_t s;
    if (!rstN) begin
      mRun = 0; mH = 0; mV = 0; mDiv = 0; mIrq = 0;
    end else begin
      bit byp, tick, fEnd, start;
      int hTot, vTot;
      byp  = !divSel || divRatioM1 == 0;
      tick = byp || mDiv >= divRatioM1;
      hTot = hSyncLen + hBackLen + hActLen + hFrontLen + 4;
      vTot = vSyncLen + vBackLen + vActLen + vFrontLen + 4;
      fEnd  = mRun && mH >= hTot-1 && mV >= vTot-1;
      start = tick && videoEn && (!mRun || fEnd);
      if (start && frameIrqEn) mIrq = 1; else if (frameIrqClr) mIrq = 0;
      mDiv = tick ? 0 : mDiv + 1;
      if (mRun && tick) begin
        if (mH >= hTot-1) begin mH = 0; mV = (mV >= vTot-1) ? 0 : mV + 1; end
        else mH = mH + 1;
      end
      if (start) mRun = 1; else if (fEnd && tick) mRun = 0;
      if (!mRun) begin mH = 0; mV = 0; end
    end
    s.run = mRun; s.h = mH; s.v = mV; s.dv = mDiv; s.irq = mIrq;
    expQ.push_back(s);
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: compare the ports against the model state
  always @(negedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      snap_t s;
      bit hs, vs, hA, vA, de, byp, pc;
      int aS, aSv;
      s = expQ.pop_front();
      hs = s.run && s.h < hSyncLen + 1;
      vs = s.run && s.v < vSyncLen + 1;
      aS = hSyncLen + hBackLen + 2;
      aSv = vSyncLen + vBackLen + 2;
      hA = s.h >= aS && s.h < aS + hActLen + 1;
      vA = s.v >= aSv && s.v < aSv + vActLen + 1;
      de = s.run && hA && vA;
      byp = !divSel || divRatioM1 == 0;
      pc = byp ? 1'b0 : (s.dv <= divRatioM1 / 2);
      check(invHsync ? "R5 hsync" : "R2 hsync", hsyncOut, hs ^ invHsync);
      check(invVsync ? "R5 vsync" : "R3 vsync", vsyncOut, vs ^ invVsync);
      check(invDe ? "R5 de" : "R4 de", deOut, de ^ invDe);
      check("R4 pixX", pixX, de ? s.h - aS : 0);
      check("R4 pixY", pixY, de ? s.v - aSv : 0);
      check("R9 frameIrq", frameIrq, s.irq);
      check(byp ? "R7 pclk" : "R6 pclk", pclkOut, pc ^ invPclk);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // count system clocks between two rising hsync edges
  task automatic linePeriod(string tag, int exp);
    int n = 0; bit prev;
    @(negedge clk); #1; prev = hsyncOut;
    while (!(hsyncOut && !prev)) begin prev = hsyncOut; @(negedge clk); #1; end
    prev = hsyncOut;
    @(negedge clk); #1; n = 1;
    while (!(hsyncOut && !prev) && n < 5000) begin prev = hsyncOut; @(negedge clk); #1; n++; end
    check(tag, n, exp);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    hSyncLen = 1; hBackLen = 1; hActLen = 3; hFrontLen = 0;
    vSyncLen = 0; vBackLen = 0; vActLen = 1; vFrontLen = 0;
    invHsync = 0; invVsync = 0; invDe = 0; invPclk = 0;
    divSel = 0; divRatioM1 = 0; videoEn = 0; frameIrqEn = 1; frameIrqClr = 0;
    cyc(3);
    @(negedge clk); #1;
    check("R1 hsync", hsyncOut, 0); check("R1 vsync", vsyncOut, 0);
    check("R1 de", deOut, 0); check("R1 irq", frameIrq, 0);
    @(posedge clk); #1; rstN = 1;
    cyc(6);
    check("R1 idle de", deOut, 0); check("R1 idle irq", frameIrq, 0);
    // R8 start, R2/R3/R4 in bypass
    videoEn = 1;
    cyc(100);
    check("R9 pending", frameIrq, 1);
    frameIrqClr = 1; cyc(1); frameIrqClr = 0;
    cyc(30);
    // R5 inversions
    invHsync = 1; invVsync = 1; invDe = 1; invPclk = 1;
    cyc(60);
    invHsync = 0; invVsync = 0; invDe = 0; invPclk = 0;
    // R7 bypass: 9-tick line
    linePeriod("R7 line period", 9);
    // R6 divide by 4
    divSel = 1; divRatioM1 = 3;
    cyc(50);
    linePeriod("R6 line period /4", 36);
    divRatioM1 = 2;
    cyc(40);
    linePeriod("R6 line period /3", 27);
    divRatioM1 = 0;
    linePeriod("R7 ratio field zero", 9);
    divSel = 0; divRatioM1 = 5;
    linePeriod("R7 select off", 9);
    // R8 stop mid-frame
    cyc(13);
    videoEn = 0;
    cyc(120);
    check("R8 stopped de", deOut, 0);
    check("R8 stopped hsync", hsyncOut, 0);
    // new timing while stopped, interrupt disabled
    hSyncLen = 3; hBackLen = 2; hActLen = 7; hFrontLen = 2;
    vSyncLen = 1; vBackLen = 1; vActLen = 3; vFrontLen = 1;
    frameIrqClr = 1; cyc(1); frameIrqClr = 0;
    frameIrqEn = 0; videoEn = 1;
    cyc(400);
    check("R10 no irq", frameIrq, 0);
    linePeriod("R2 line period 18", 18);
    // R9 set wins over a clear held high
    frameIrqEn = 1; frameIrqClr = 1;
    cyc(400);
    frameIrqClr = 0;
    cyc(200);
    check("R9 pending again", frameIrq, 1);
    cyc(5);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule